// File: doc/BRIEF.md
# Stepper Motor Phase Sequencer

This block drives the four winding control lines of a two-phase unipolar stepper motor: winding A, its complement A_n, winding B, and its complement B_n. Each rising edge on the step input moves the excitation pattern by one position. Mode and direction inputs choose between full-step (two windings on at a time) and half-step (one and two windings alternating), and whether the pattern walks forward or backward. All inputs are asynchronous to the system clock. Each passes through a two-flop synchronizer, and the outputs come straight from flops, so they never glitch.

The active-low reset turns every output off. Inside the block, reset lasts for at least `RESET_US` microseconds, even when the external pulse is shorter. After that, a lockout of `LOCK_US` microseconds ignores step edges. During the lockout the home pattern (A with B_n) is already driven. Both times are counted in system-clock cycles from `CLK_MHZ`. The enable input blanks all outputs and holds the current position. When enable returns high, stepping continues from that position.

Top module: `stepper_phase_seq`

## Requirements
- R1: The position moves by one step per rising edge of the synchronized step input. A step input held high produces only one step, and a falling edge produces none.
- R2: With `half_mode` = 0 and `dir_rev` = 0, the output word {out_a, out_a_n, out_b, out_b_n} cycles 1001 → 1010 → 0110 → 0101 → 1001.
- R3: With `half_mode` = 1 and `dir_rev` = 0, the output word cycles 1001 → 1000 → 1010 → 0010 → 0110 → 0100 → 0101 → 0001 → 1001.
- R4: With `dir_rev` = 1, the same sequences are walked in the opposite order.
- R5: From 4 clock cycles after `rst_n` goes low, all four outputs are 0. The internal reset lasts at least `CLK_MHZ*RESET_US` cycles from assertion, even when `rst_n` returns high sooner.
- R6: When the internal reset ends, the output word is 1001 (A with B_n) while `drv_en` is high.
- R7: For `CLK_MHZ*LOCK_US` cycles after the internal reset ends, step edges are ignored. Steps are accepted after that window.
- R8: While `drv_en` is low, all outputs are 0 and step edges are ignored. After `drv_en` returns high, the output word equals the one shown before it went low.
- R9: In full-step mode, a step taken from a single-winding (half-step-only) state moves to the adjacent two-winding state in the selected direction.
- R10: A winding and its complement are never both on, and at most two outputs are high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset request |
| step_in | input | 1 | Step clock; its rising edge advances the position |
| half_mode | input | 1 | 0 = full-step, 1 = half-step |
| dir_rev | input | 1 | 0 = forward, 1 = reverse |
| drv_en | input | 1 | High enables the outputs; low blanks them and freezes the position |
| out_a | output | 1 | Winding A drive |
| out_a_n | output | 1 | Winding A complement drive |
| out_b | output | 1 | Winding B drive |
| out_b_n | output | 1 | Winding B complement drive |

## Verification
The position index can only be observed through the decoded pattern. A corrupted index therefore shows up on the very next output word, about four cycles after a step edge, as a wrong pattern or a broken sequence order. A fault in the lockout or reset-stretch counters shows up as outputs lit too early or a step accepted inside the window. Such a fault is seen only at the window boundary, a thousand or more cycles after reset. A wrong position after enable is released, or a wrong landing after a mode change, appears on the first output word afterwards.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;
    typedef enum logic [1:0] {
        PH_RESET = 2'd0,
        PH_LOCK  = 2'd1,
        PH_RUN   = 2'd2
    } phase_e;

    localparam int POS_W = 3;
    typedef logic [POS_W-1:0] pos_t;
    // bit order {A, A_n, B, B_n}
    typedef logic [3:0] drv_t;
endpackage

// File: rtl/stepseq_sync.sv
module stepseq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk) begin
        chain_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            chain_q[s] <= chain_q[s-1];
        end
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/stepseq_advance.sv
module stepseq_advance
    import stepseq_pkg::*;
(
    input  pos_t pos,
    input  logic half,
    input  logic rev,
    output pos_t nxt
);
    pos_t stride;

    always_comb begin
        // odd index = single-winding state; full-step from there lands on neighbour
        stride = (half || pos[0]) ? pos_t'(1) : pos_t'(2);
        nxt    = rev ? pos - stride : pos + stride;
    end
endmodule

// File: rtl/stepseq_decode.sv
module stepseq_decode
    import stepseq_pkg::*;
(
    input  pos_t pos,
    output drv_t drv
);
    // windings in ring order A, B, A_n, B_n; each lit for 3 of 8 positions
    localparam int BIT_OF [4] = '{3, 1, 2, 0};

    for (genvar k = 0; k < 4; k++) begin : g_wind
        pos_t rel;
        assign rel = pos - pos_t'(2 * k);
        assign drv[BIT_OF[k]] = (rel < pos_t'(3));
    end
endmodule

// File: rtl/stepper_phase_seq.sv
module stepper_phase_seq
    import stepseq_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int RESET_US = 10,
    parameter int LOCK_US  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_in,
    input  logic half_mode,
    input  logic dir_rev,
    input  logic drv_en,
    output logic out_a,
    output logic out_a_n,
    output logic out_b,
    output logic out_b_n
);
    localparam int RST_CYC  = CLK_MHZ * RESET_US;
    localparam int LOCK_CYC = CLK_MHZ * LOCK_US;
    localparam int CNT_MAX  = (RST_CYC > LOCK_CYC) ? RST_CYC : LOCK_CYC;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        pos_t               pos;
        logic               step_prev;
        drv_t               drv;
    } state_t;

    state_t state_d, state_q;

    logic [4:0] raw_in, syn;
    logic rst_s, step_s, half_s, rev_s, en_s;

    assign raw_in = {rst_n, step_in, half_mode, dir_rev, drv_en};

    stepseq_sync #(.W(5), .STAGES(2)) i_sync (
        .clk (clk),
        .d   (raw_in),
        .q   (syn)
    );

    assign {rst_s, step_s, half_s, rev_s, en_s} = syn;

    pos_t pos_nxt;
    drv_t drv_dec;

    stepseq_advance i_adv (
        .pos  (state_q.pos),
        .half (half_s),
        .rev  (rev_s),
        .nxt  (pos_nxt)
    );

    stepseq_decode i_dec (
        .pos (state_q.pos),
        .drv (drv_dec)
    );

    // observation points for the bound checker
    pos_t   pos_q;
    phase_e phase_q;
    logic   step_prev_q;
    assign pos_q       = state_q.pos;
    assign phase_q     = state_q.phase;
    assign step_prev_q = state_q.step_prev;

    always_comb begin
        state_d           = state_q;
        state_d.step_prev = step_s;
        state_d.drv       = (state_q.phase != PH_RESET && en_s) ? drv_dec : '0;

        unique case (state_q.phase)
            PH_RESET: begin
                state_d.pos = '0;
                if (state_q.cnt != CNT_W'(RST_CYC)) begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end else if (rst_s) begin
                    state_d.phase = PH_LOCK;
                    state_d.cnt   = '0;
                end
            end
            PH_LOCK: begin
                if (state_q.cnt == CNT_W'(LOCK_CYC)) begin
                    state_d.phase = PH_RUN;
                    state_d.cnt   = '0;
                end else begin
                    state_d.cnt = state_q.cnt + 1'b1;
                end
            end
            PH_RUN: begin
                if (step_s && !state_q.step_prev && en_s) begin
                    state_d.pos = pos_nxt;
                end
            end
            default: begin
                state_d.phase = PH_RESET;
                state_d.cnt   = '0;
            end
        endcase

        if (!rst_s && state_q.phase != PH_RESET) begin
            state_d.phase = PH_RESET;
            state_d.cnt   = '0;
            state_d.pos   = '0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign {out_a, out_a_n, out_b, out_b_n} = state_q.drv;
endmodule

// File: rtl/stepseq_chk.sv
module stepseq_chk
    import stepseq_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   rst_s,
    input logic   step_s,
    input logic   half_s,
    input logic   en_s,
    input logic   step_prev_q,
    input pos_t   pos_q,
    input phase_e phase_q,
    input logic   out_a,
    input logic   out_a_n,
    input logic   out_b,
    input logic   out_b_n
);
    logic in_reset_q;
    always_ff @(posedge clk) in_reset_q <= (phase_q == PH_RESET);

    // R5: the cycle after the reset phase, every output is dark
    always @(negedge clk) begin
        if (in_reset_q) begin
            assert_reset_dark_R5: assert ({out_a, out_a_n, out_b, out_b_n} == 4'b0000);
        end
    end

    assert_no_shoot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_a && out_a_n) && !(out_b && out_b_n));

    assert_max_two_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({out_a, out_a_n, out_b, out_b_n}) <= 2);

    assert_blank_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> ({out_a, out_a_n, out_b, out_b_n} == 4'b0000));

    assert_freeze_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_s && rst_s) |=> $stable(pos_q));

    assert_lock_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_RUN) |=> (pos_q == '0));

    assert_edge_only_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_s && !(step_s && !step_prev_q)) |=> $stable(pos_q));

    assert_full_even_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_s && en_s && !half_s && step_s && !step_prev_q) |=> !pos_q[0]);
endmodule

bind stepper_phase_seq stepseq_chk i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_s       (rst_s),
    .step_s      (step_s),
    .half_s      (half_s),
    .en_s        (en_s),
    .step_prev_q (step_prev_q),
    .pos_q       (pos_q),
    .phase_q     (phase_q),
    .out_a       (out_a),
    .out_a_n     (out_a_n),
    .out_b       (out_b),
    .out_b_n     (out_b_n)
);

// File: tb/test_stepper_phase_seq.sv
module test_stepper_phase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    // {half_mode, dir_rev, expected {A, A_n, B, B_n}}
    localparam logic [5:0] VEC [NV] = '{
        6'b00_1010, 6'b00_0110, 6'b00_0101, 6'b00_1001,   // R2 incl. wrap
        6'b01_0101, 6'b01_0110,                           // R4 full reverse
        6'b10_0100, 6'b10_0101, 6'b10_0001, 6'b10_1001,   // R3 incl. wrap
        6'b11_0001, 6'b11_0101, 6'b11_0100,               // R4 half reverse
        6'b00_0101,                                       // R9 odd -> forward neighbour
        6'b11_0100,
        6'b01_0110,                                       // R9 odd -> reverse neighbour
        6'b10_0100,
        6'b01_0110                                        // R9
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0, step_in = 1'b0, half_mode = 1'b0, dir_rev = 1'b0, drv_en = 1'b1;
    logic out_a, out_a_n, out_b, out_b_n;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    stepper_phase_seq i_stepper_phase_seq (
        .clk, .rst_n, .step_in, .half_mode, .dir_rev, .drv_en,
        .out_a, .out_a_n, .out_b, .out_b_n
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_step();
        step_in = 1'b1;
        wait_cyc(5);
        step_in = 1'b0;
        wait_cyc(6);
    endtask

    task automatic check(input logic [3:0] exp, input string tag);
        logic [3:0] got;
        got = {out_a, out_a_n, out_b, out_b_n};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b, expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected finish");
        finish_run();
    end

    initial begin
        // power-on reset: short external pulse, internal reset is stretched
        wait_cyc(20);
        check(4'b0000, "R5 reset state");
        rst_n = 1'b1;
        wait_cyc(200);
        check(4'b0000, "R5 stretch");
        wait_cyc(980);                    // inside lockout now
        check(4'b1001, "R6 home");
        pulse_step();
        check(4'b1001, "R7 lockout ignores step");
        wait_cyc(400);                    // run phase

        for (int i = 0; i < NV; i++) begin
            string tag;
            half_mode = VEC[i][5];
            dir_rev   = VEC[i][4];
            pulse_step();
            tag = VEC[i][4] ? "R4" : (VEC[i][5] ? "R3" : "R2");
            check(VEC[i][3:0], tag);
            if ($countones({out_a, out_a_n, out_b, out_b_n}) > 2)
                check(4'b0000, "R10 too many windings");
        end

        // R1: held-high step counts once, falling edge counts nothing
        half_mode = 1'b0;
        dir_rev   = 1'b0;
        step_in   = 1'b1;
        wait_cyc(10);
        check(4'b0101, "R1 first edge");
        wait_cyc(30);
        check(4'b0101, "R1 held high");
        step_in = 1'b0;
        wait_cyc(10);
        check(4'b0101, "R1 falling edge");

        // R8: enable blanking and position hold
        drv_en = 1'b0;
        wait_cyc(6);
        check(4'b0000, "R8 blank");
        pulse_step();
        check(4'b0000, "R8 blank during step");
        drv_en = 1'b1;
        wait_cyc(6);
        check(4'b0101, "R8 resume same position");
        pulse_step();
        check(4'b1001, "R8 continues after resume");

        // R5/R6/R7: reset mid-run with a short pulse
        pulse_step();
        check(4'b1010, "R2 before reset");
        rst_n = 1'b0;
        wait_cyc(5);
        check(4'b0000, "R5 reset blanks");
        rst_n = 1'b1;
        wait_cyc(300);
        check(4'b0000, "R5 stretch after short pulse");
        wait_cyc(800);
        check(4'b1001, "R6 home after reset");
        pulse_step();
        check(4'b1001, "R7 lockout again");
        wait_cyc(400);
        pulse_step();
        check(4'b1010, "R7 accepted after lockout");

        finish_run();
    end
endmodule